// File: doc/BRIEF.md
# Memory Access Qualifier with Power-of-Two Downsampler

This block sits in front of a bank of access-frequency counters and decides which raw memory accesses are worth counting. Each access arrives as a one-cycle strobe with a device-side address, a write flag and a trusted-execution flag. The block passes an access on only when three conditions hold. Its read/write and trust attributes must match a programmed selection code. Its 256 MiB address chunk must be enabled in a region bitmap, which is built from a base chunk and a chunk count. It must also be chosen by a downsampler that forwards one of every 2^k qualifying accesses.

Each forwarded access leaves as a strobe with a unit index: the address divided by a programmable power-of-two unit size of at least 256 bytes. The downsampler can run with a fixed spacing, or with a spacing that a linear feedback shift register varies around the chosen factor. The randomized mode keeps periodic traffic from aliasing with the sampling grid. Configuration inputs are expected to stay stable while the block is out of reset.

Top module: `mem_access_sampler`

## Requirements
- R1: With selection code 1 only reads (acc_write=0) that are not trusted (acc_trusted=0) qualify. Code 2 admits only untrusted writes and code 3 any untrusted access. Code 4 admits every read, code 5 every write and code 6 every access.
- R2: Selection code 0 and selection code 7 let no access qualify.
- R3: The chunk of an access is acc_addr[35:28]. The region bitmap has one bit per chunk, and bit i is set when base <= i < base+size. Bits past chunk 255 do not exist, so the run does not wrap. A size of 0 sets no bit, and an access whose chunk bit is clear never qualifies.
- R4: hit_unit equals acc_addr shifted right by the unit-size log2, truncated to 28 bits.
- R5: A unit-size log2 below 8 is treated as 8, which makes 256 bytes the smallest unit.
- R6: With randomization off, and also with cfg_ds_log2 below 2, the block emits the F-th, 2F-th, 3F-th ... qualifying access since reset, where F = 2^cfg_ds_log2 and cfg_ds_log2 runs from 0 to 15. Every qualifying access passes when F = 1.
- R7: With randomization on and F >= 4, the number of qualifying accesses in each sampling interval lies in [F - F/4, F + F/4 - 1]. An interval is counted from reset or from the previous emitted access, and includes the emitted one.
- R8: With randomization on, the mean interval over 64 emitted accesses is within F/8 of F.
- R9: hit_valid rises exactly two clock cycles after the acc_valid of the access it carries. Accesses that do not qualify never advance the downsampling count.
- R10: While rst is high hit_valid is 0, and after reset the downsampling count starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_access_sel | input | 3 | Access selection code (0..7) |
| cfg_region_base | input | 8 | First enabled 256 MiB chunk |
| cfg_region_size | input | 9 | Number of enabled chunks (0..256) |
| cfg_unit_log2 | input | 6 | log2 of unit size in bytes |
| cfg_ds_log2 | input | 4 | log2 of the downsampling factor |
| cfg_ds_random | input | 1 | Randomized sampling spacing enable |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 36 | Device physical address of the access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_trusted | input | 1 | 1 = access carries the trusted-execution flag |
| hit_valid | output | 1 | Sampled access strobe |
| hit_unit | output | 28 | Unit index of the sampled access |

## Verification
A corrupted downsampling count or a wrong interval limit shifts the phase of every later hit_valid pulse. A single slip therefore shows up as a mismatch at the first expected sample after the fault, at most F qualifying accesses later. A wrong bitmap bit or a wrong selection decode shows up two cycles after the first access that touches that chunk or attribute combination. A bad shift clamp corrupts hit_unit on the very next emitted access. The bench models every cycle exactly in fixed-spacing mode. In randomized mode it bounds each interval and the mean interval, so a stuck or badly masked shift register breaks the bounds within a few intervals.

// File: rtl/acq_pkg.sv
package acq_pkg;

    // Geometry constants shared by all sub-blocks
    parameter int ADDR_W        = 36;
    parameter int CHUNK_LOG2    = 28;                 // 256 MiB per bitmap bit
    parameter int MIN_UNIT_LOG2 = 8;                  // 256-byte minimum unit
    parameter int UNIT_LOG2_W   = 6;
    parameter int DS_LOG2_W     = 4;
    parameter int CNT_W         = 16;
    parameter int LFSR_W        = 16;

    localparam int CHUNK_W    = ADDR_W - CHUNK_LOG2;
    localparam int NUM_CHUNKS = 1 << CHUNK_W;
    localparam int UNIT_W     = ADDR_W - MIN_UNIT_LOG2;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    typedef enum logic [2:0] {
        SEL_OFF      = 3'd0,
        SEL_UNT_RD   = 3'd1,
        SEL_UNT_WR   = 3'd2,
        SEL_UNT_RW   = 3'd3,
        SEL_ANY_RD   = 3'd4,
        SEL_ANY_WR   = 3'd5,
        SEL_ANY_RW   = 3'd6,
        SEL_RESERVED = 3'd7
    } acc_sel_e;

    // Qualified access moving between pipeline stages
    typedef struct packed {
        logic              valid;
        logic [UNIT_W-1:0] unit;
    } qual_evt_t;

    function automatic logic sel_match(input acc_sel_e sel, input logic wr, input logic tr);
        logic ok;
        unique case (sel)
            SEL_UNT_RD: ok = !tr && !wr;
            SEL_UNT_WR: ok = !tr &&  wr;
            SEL_UNT_RW: ok = !tr;
            SEL_ANY_RD: ok = !wr;
            SEL_ANY_WR: ok =  wr;
            SEL_ANY_RW: ok = 1'b1;
            default:    ok = 1'b0;
        endcase
        return ok;
    endfunction

    // Number of qualifying accesses that make up the current sampling interval
    function automatic logic [CNT_W-1:0] ds_interval(input logic [DS_LOG2_W-1:0] lg,
                                                     input logic rnd,
                                                     input logic [LFSR_W-1:0] lf);
        logic [CNT_W:0] f;
        logic [CNT_W:0] lo;
        logic [CNT_W:0] mask;
        logic [CNT_W:0] r;
        f = (CNT_W+1)'(1) << lg;
        if (!rnd || lg < DS_LOG2_W'(2)) begin
            r = f;
        end else begin
            lo   = f - (f >> 2);
            mask = (f >> 1) - (CNT_W+1)'(1);
            r    = lo + (mask & {1'b0, lf});
        end
        return r[CNT_W-1:0];
    endfunction

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/acq_region_map.sv
module acq_region_map
    import acq_pkg::*;
(
    input  logic [CHUNK_W-1:0] chunk,
    input  logic [CHUNK_W-1:0] base,
    input  logic [CHUNK_W:0]   size,
    output logic               hit
);

    logic [NUM_CHUNKS-1:0] bitmap;

    // One enable bit per chunk: set when the chunk lies inside [base, base+size)
    for (genvar g = 0; g < NUM_CHUNKS; g++) begin : g_bit
        localparam logic [CHUNK_W:0] IDX = (CHUNK_W+1)'(g);
        assign bitmap[g] = ({1'b0, base} <= IDX) && ((IDX - {1'b0, base}) < size);
    end

    assign hit = bitmap[chunk];

endmodule

// File: rtl/acq_unit_index.sv
module acq_unit_index
    import acq_pkg::*;
(
    input  logic [ADDR_W-1:0]      addr,
    input  logic [UNIT_LOG2_W-1:0] unit_log2,
    output logic [UNIT_W-1:0]      unit
);

    logic [UNIT_LOG2_W-1:0] shift;

    assign shift = (unit_log2 < UNIT_LOG2_W'(MIN_UNIT_LOG2)) ? UNIT_LOG2_W'(MIN_UNIT_LOG2)
                                                             : unit_log2;
    assign unit  = UNIT_W'(addr >> shift);

endmodule

// File: rtl/acq_downsampler.sv
module acq_downsampler
    import acq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DS_LOG2_W-1:0] ds_log2,
    input  logic                 ds_random,
    input  qual_evt_t            q_in,
    output qual_evt_t            q_out
);

    logic [CNT_W-1:0]  cnt;
    logic [LFSR_W-1:0] lfsr;
    logic [CNT_W-1:0]  limit;
    logic [CNT_W:0]    cnt_inc;
    logic              fire;

    assign limit   = ds_interval(ds_log2, ds_random, lfsr);
    assign cnt_inc = {1'b0, cnt} + (CNT_W+1)'(1);
    assign fire    = q_in.valid && (cnt_inc >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            lfsr  <= LFSR_SEED;
            q_out <= '0;
        end else begin
            q_out.valid <= fire;
            if (fire) q_out.unit <= q_in.unit;
            if (q_in.valid) begin
                if (fire) begin
                    cnt  <= '0;
                    lfsr <= lfsr_step(lfsr);
                end else begin
                    cnt <= cnt_inc[CNT_W-1:0];
                end
            end
        end
    end

    // R9: every emitted access comes from a qualified access one cycle earlier
    p_src_qualified_r9: assert property (@(posedge clk) disable iff (rst)
        q_out.valid |-> $past(q_in.valid));

    // R6: factor one forwards every qualifying access
    p_full_rate_r6: assert property (@(posedge clk) disable iff (rst)
        (q_in.valid && ds_log2 == '0) |=> q_out.valid);

    // R7: with a factor above one, two emitted accesses never sit back to back
    p_no_adjacent_r7: assert property (@(posedge clk) disable iff (rst)
        (q_out.valid && ds_log2 != '0) ##1 $stable(ds_log2) |-> !q_out.valid);

endmodule

// File: rtl/mem_access_sampler.sv
module mem_access_sampler
    import acq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [2:0]             cfg_access_sel,
    input  logic [CHUNK_W-1:0]     cfg_region_base,
    input  logic [CHUNK_W:0]       cfg_region_size,
    input  logic [UNIT_LOG2_W-1:0] cfg_unit_log2,
    input  logic [DS_LOG2_W-1:0]   cfg_ds_log2,
    input  logic                   cfg_ds_random,
    input  logic                   acc_valid,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic                   acc_write,
    input  logic                   acc_trusted,
    output logic                   hit_valid,
    output logic [UNIT_W-1:0]      hit_unit
);

    logic              type_ok;
    logic              region_ok;
    logic [UNIT_W-1:0] unit_idx;
    qual_evt_t         s1;
    qual_evt_t         s2;

    assign type_ok = sel_match(acc_sel_e'(cfg_access_sel), acc_write, acc_trusted);

    acq_region_map u_region (
        .chunk (acc_addr[ADDR_W-1:CHUNK_LOG2]),
        .base  (cfg_region_base),
        .size  (cfg_region_size),
        .hit   (region_ok)
    );

    acq_unit_index u_unit (
        .addr      (acc_addr),
        .unit_log2 (cfg_unit_log2),
        .unit      (unit_idx)
    );

    // Stage 1: qualification result registered
    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.valid <= acc_valid && type_ok && region_ok;
            s1.unit  <= unit_idx;
        end
    end

    // Stage 2: downsampling decision registered
    acq_downsampler u_ds (
        .clk       (clk),
        .rst       (rst),
        .ds_log2   (cfg_ds_log2),
        .ds_random (cfg_ds_random),
        .q_in      (s1),
        .q_out     (s2)
    );

    assign hit_valid = s2.valid;
    assign hit_unit  = s2.unit;

    // R2: blocking codes never produce a qualified access
    p_block_codes_r2: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && (cfg_access_sel == 3'd0 || cfg_access_sel == 3'd7)) |=> !s1.valid);

    // R3: an empty region admits nothing
    p_empty_region_r3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && cfg_region_size == '0) |=> !s1.valid);

    // R5: small unit sizes fall back to the 256-byte unit
    p_unit_clamp_r5: assert property (@(posedge clk) disable iff (rst)
        (s1.valid && $past(cfg_unit_log2) < UNIT_LOG2_W'(MIN_UNIT_LOG2))
        |-> s1.unit == $past(acc_addr[ADDR_W-1:MIN_UNIT_LOG2]));

    // R10: nothing is emitted in the cycle after a reset
    p_reset_quiet_r10: assert property (@(posedge clk)
        $past(rst) |-> !hit_valid);

endmodule

// File: tb/mem_access_sampler_tb_top.sv
module mem_access_sampler_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  cfg_access_sel;
    logic [7:0]  cfg_region_base;
    logic [8:0]  cfg_region_size;
    logic [5:0]  cfg_unit_log2;
    logic [3:0]  cfg_ds_log2;
    logic        cfg_ds_random;
    logic        acc_valid;
    logic [35:0] acc_addr;
    logic        acc_write;
    logic        acc_trusted;
    logic        hit_valid;
    logic [27:0] hit_unit;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2ns clk = ~clk;

    mem_access_sampler dut_i (
        .clk(clk), .rst(rst),
        .cfg_access_sel(cfg_access_sel), .cfg_region_base(cfg_region_base),
        .cfg_region_size(cfg_region_size), .cfg_unit_log2(cfg_unit_log2),
        .cfg_ds_log2(cfg_ds_log2), .cfg_ds_random(cfg_ds_random),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
        .acc_trusted(acc_trusted), .hit_valid(hit_valid), .hit_unit(hit_unit)
    );

    // Expected-value model
    function automatic bit m_sel(int sel, bit w, bit t);
        case (sel)
            1: return !t && !w;
            2: return !t && w;
            3: return !t;
            4: return !w;
            5: return w;
            6: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit m_region(logic [35:0] a);
        int c = int'(a[35:28]);
        return (c >= int'(cfg_region_base)) && (c < int'(cfg_region_base) + int'(cfg_region_size));
    endfunction

    function automatic logic [27:0] m_unit(logic [35:0] a);
        int sh = (cfg_unit_log2 < 8) ? 8 : int'(cfg_unit_log2);
        longint unsigned v = longint'(a) >> sh;
        return v[27:0];
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; acc_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(hit_valid == 1'b0, "R10", "hit_valid in reset", hit_valid, 0);
        rst = 1'b0;
    endtask

    // Drive n cycles; density is percent of cycles with an access
    task automatic run(int n, int density, string tag);
        bit          p1_v = 0, p2_v = 0;
        logic [27:0] p1_u = '0, p2_u = '0;
        int cnt = 0, since = 0, passes = 0, gsum = 0;
        int f = 1 << cfg_ds_log2;
        bit rnd = cfg_ds_random && (cfg_ds_log2 >= 2);
        for (int i = 0; i < n + 2; i++) begin
            @(negedge clk);
            if (!rnd) begin
                bit ev = 1'b0;
                if (p2_v) begin
                    cnt++;
                    if (cnt == f) begin ev = 1'b1; cnt = 0; end
                end
                check(hit_valid == ev, tag, "hit_valid", hit_valid, ev);
                if (ev) check(hit_unit == p2_u, "R4 R5", "hit_unit", hit_unit, p2_u);
            end else begin
                if (p2_v) since++;
                if (hit_valid) begin
                    check(p2_v, "R9", "emitted without qualified source", 1, 0);
                    check(hit_unit == p2_u, "R4", "hit_unit", hit_unit, p2_u);
                    check(since >= f - f/4 && since <= f + f/4 - 1, "R7",
                          "interval", since, f);
                    passes++; gsum += since; since = 0;
                end
            end
            p2_v = p1_v; p2_u = p1_u;
            if (i < n && $urandom_range(99) < density) begin
                logic [35:0] a;
                a = {$urandom, $urandom};
                if ($urandom_range(1) == 1) begin
                    int c = int'(cfg_region_base) - 2 + $urandom_range(cfg_region_size + 4);
                    if (c < 0) c = 0;
                    if (c > 255) c = 255;
                    a[35:28] = 8'(c);
                end
                acc_valid   = 1'b1;
                acc_addr    = a;
                acc_write   = 1'($urandom_range(1));
                acc_trusted = 1'($urandom_range(1));
                p1_v = m_sel(int'(cfg_access_sel), acc_write, acc_trusted) && m_region(a);
                p1_u = m_unit(a);
            end else begin
                acc_valid = 1'b0;
                p1_v = 1'b0;
            end
        end
        if (rnd && passes >= 64)
            check((gsum - passes * f) <= passes * f / 8 && (passes * f - gsum) <= passes * f / 8,
                  "R8", "mean interval sum", gsum, passes * f);
    endtask

    task automatic set_cfg(int sel, int base, int size, int ul, int ds, bit rnd);
        cfg_access_sel  = 3'(sel);
        cfg_region_base = 8'(base);
        cfg_region_size = 9'(size);
        cfg_unit_log2   = 6'(ul);
        cfg_ds_log2     = 4'(ds);
        cfg_ds_random   = rnd;
    endtask

    initial begin
        #(4ns * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20241121));
        rst = 1'b1; acc_valid = 1'b0; acc_addr = '0; acc_write = 1'b0; acc_trusted = 1'b0;
        set_cfg(6, 0, 256, 12, 0, 1'b0);

        // R1, R2: every selection code at full rate over the whole space
        for (int s = 0; s < 8; s++) begin
            set_cfg(s, 0, 256, 12, 0, 1'b0);
            do_reset();
            run(200, 80, (s == 0 || s == 7) ? "R2" : "R1 R9");
        end

        // R3: regions at the top edge (no wrap), single chunk, empty
        set_cfg(6, 250, 20, 16, 0, 1'b0); do_reset(); run(300, 90, "R3");
        set_cfg(3, 17, 1, 20, 0, 1'b0);   do_reset(); run(300, 90, "R3");
        set_cfg(6, 40, 0, 12, 0, 1'b0);   do_reset(); run(200, 90, "R3");

        // R5: unit size log2 below the minimum
        set_cfg(6, 0, 256, 3, 0, 1'b0);   do_reset(); run(200, 90, "R5");
        set_cfg(6, 0, 256, 35, 1, 1'b0);  do_reset(); run(200, 90, "R4 R6");

        // R6, R9: fixed spacing, sparse and dense traffic
        set_cfg(4, 0, 256, 12, 3, 1'b0);  do_reset(); run(600, 30, "R6 R9");
        set_cfg(6, 0, 256, 12, 15, 1'b0); do_reset(); run(32800, 100, "R6");
        // random mode with a factor below four behaves as fixed spacing
        set_cfg(6, 0, 256, 12, 1, 1'b1);  do_reset(); run(300, 70, "R6");

        // R10: reset mid-interval restarts the count
        set_cfg(6, 0, 256, 12, 2, 1'b0);  do_reset(); run(5, 100, "R10");
        do_reset(); run(100, 100, "R10 R6");

        // Constrained random configurations
        for (int k = 0; k < 16; k++) begin
            set_cfg($urandom_range(7), $urandom_range(255), $urandom_range(256),
                    $urandom_range(35), $urandom_range(5), 1'($urandom_range(1)));
            do_reset();
            run(600, $urandom_range(40, 100), "R1 R3 R6");
        end

        // R7, R8: randomized spacing
        set_cfg(6, 0, 256, 12, 4, 1'b1);  do_reset(); run(1200, 100, "R7");
        set_cfg(5, 0, 256, 9, 6, 1'b1);   do_reset(); run(9000, 100, "R7");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule